// File: doc/BRIEF.md
# Single-Cycle 16-bit Register Processor Core

This block is a small processor that completes one 16-bit instruction in every clock cycle. In that one cycle it fetches the word at the program counter, decodes it, reads up to two of eight 16-bit general registers and computes a result or an address. It then reads or writes data memory, writes a register back and chooses the next program counter. A three-bit negative/zero/positive condition register records the sign of the last value written to a register, and conditional branches test it.

Instruction storage and data storage are two separate word-addressed arrays inside the block. The core has no path that writes instruction storage, so a loader port fills either array. It is meant to be used while the core is held in reset. One adder serves every memory address and every branch target. Its base is either the incremented program counter or a register, and its offset is a sign-extended field of the instruction. Debug outputs show the program counter, all eight registers and the condition register. An integration or test environment uses them to follow execution.

Top module: `oc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes RESET_PC (default 16'h3000), all eight registers become 0 and the condition output `{n,z,p}` becomes 3'b010.
- R2: Opcode [15:12]=0001 adds and 0101 bitwise-ANDs the register named in [8:6] with a second operand, writing the register in [11:9]. When bit 5 is 0 the second operand is the register in [2:0]. When bit 5 is 1 it is [4:0] sign-extended to 16 bits.
- R3: Opcode 1001 writes the bitwise complement of register [8:6] into register [11:9].
- R4: Opcodes 0010 and 1110 form an address as (PC+1) plus [8:0] sign-extended. 0010 loads the data word at that address into register [11:9]. 1110 writes the address itself into register [11:9].
- R5: Opcode 0110 loads into register [11:9] the data word at register [8:6] plus [5:0] sign-extended. This holds even when [11:9] names the same register as [8:6].
- R6: Opcode 0011 stores register [11:9] at the (PC+1)-relative address of R4. Opcode 0111 stores it at the base-plus-offset address of R5. The word is committed at the clock edge and is visible to the next instruction. Stores change neither the registers nor the condition code.
- R7: Opcode 0000 with selection bits [11:9]={n,z,p} moves the PC to (PC+1)+sext([8:0]) when any selected flag is set, and to PC+1 otherwise. A selection of 000 never branches and 111 always branches. No register or condition flag changes.
- R8: Opcode 1100 loads the PC with the register named in [8:6].
- R9: Each register write sets exactly one of n (bit 15 set), z (value zero) or p (otherwise) from the written value. The flags appear on `dbg_cc` as {n,z,p}.
- R10: Opcodes 0100, 1000, 1010, 1011, 1101 and 1111 advance the PC by one and change no register, flag or data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Loader target: 0 instruction array, 1 data array |
| ld_addr | input | LDAW (8) | Loader word index |
| ld_data | input | 16 | Loader write word |
| dbg_pc | output | 16 | Current program counter |
| dbg_regs | output | 128 | Registers 0..7, register k in bits [16k+15:16k] |
| dbg_cc | output | 3 | Condition flags {n,z,p} |

## Verification
Two functions can fall in the same cycle. A base-plus-offset load whose destination is its own base register reads the old register value for the address and writes the loaded word over it. A store commits its word at the edge where the next instruction, a load from the same address, begins. The directed program places both pairs back to back. A branch follows right after a flag-setting instruction, and a register-indirect jump follows right after an address-forming instruction. A behavioural model in the bench then compares the PC, flags and every register after each edge, and that comparison decides whether the result is right. A random instruction stream then exercises all opcodes with arbitrary register, offset and memory contents.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int W = 16;

  typedef enum logic [3:0] {
    OP_BR   = 4'b0000,
    OP_ADD  = 4'b0001,
    OP_LDPC = 4'b0010,
    OP_STPC = 4'b0011,
    OP_AND  = 4'b0101,
    OP_LDBO = 4'b0110,
    OP_STBO = 4'b0111,
    OP_INV  = 4'b1001,
    OP_JREG = 4'b1100,
    OP_ADDR = 4'b1110
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_INV} alu_fn_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_AGU} wb_sel_e;

  function automatic logic [2:0] flags_of(input logic [W-1:0] v);
    if (v[W-1])     return 3'b100;
    else if (v == 0) return 3'b010;
    else            return 3'b001;
  endfunction
endpackage

// File: rtl/oc_regfile.sv
module oc_regfile import oc_pkg::*; #(
  parameter int NREG = 8,
  localparam int RAW = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [RAW-1:0]   wa,
  input  logic [W-1:0]     wd,
  input  logic [RAW-1:0]   ra,
  input  logic [RAW-1:0]   rb,
  output logic [W-1:0]     rda,
  output logic [W-1:0]     rdb,
  output logic [NREG*W-1:0] regs_flat
);
  logic [W-1:0] r [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) r[i] <= '0;
    end else if (we) begin
      r[wa] <= wd;
    end
  end

  assign rda = r[ra];
  assign rdb = r[rb];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*W +: W] = r[g];
  end

  AST_RF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(regs_flat)); // R10
endmodule

// File: rtl/oc_agu.sv
module oc_agu import oc_pkg::*; (
  input  logic [W-1:0] pc1,
  input  logic [W-1:0] base,
  input  logic [8:0]   off,
  input  logic         use_base,
  output logic [W-1:0] addr
);
  logic [W-1:0] sx6, sx9, lhs, rhs;

  assign sx6  = {{(W-6){off[5]}}, off[5:0]};
  assign sx9  = {{(W-9){off[8]}}, off};
  assign lhs  = use_base ? base : pc1;
  assign rhs  = use_base ? sx6  : sx9;
  assign addr = lhs + rhs;
endmodule

// File: rtl/oc_alu.sv
module oc_alu import oc_pkg::*; (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         imm_en,
  input  logic [4:0]   imm,
  output logic [W-1:0] y
);
  logic [W-1:0] opb;

  assign opb = imm_en ? {{(W-5){imm[4]}}, imm} : b;

  always_comb begin
    case (fn)
      ALU_AND: y = a & opb;
      ALU_INV: y = ~a;
      default: y = a + opb;
    endcase
  end
endmodule

// File: rtl/oc_core.sv
module oc_core import oc_pkg::*; #(
  parameter logic [15:0] RESET_PC   = 16'h3000,
  parameter int          IMEM_DEPTH = 256,
  parameter int          DMEM_DEPTH = 256,
  localparam int IAW  = $clog2(IMEM_DEPTH),
  localparam int DAW  = $clog2(DMEM_DEPTH),
  localparam int LDAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [15:0]     ld_data,
  output logic [15:0]     dbg_pc,
  output logic [127:0]    dbg_regs,
  output logic [2:0]      dbg_cc
);
  logic [W-1:0] imem [IMEM_DEPTH];
  logic [W-1:0] dmem [DMEM_DEPTH];

  logic [W-1:0] pc_q, pc1, pc_nx, instr, rda, rdb, alu_y, addr, dm_rd, wd;
  logic [2:0]   cc_q, rb_sel;
  opcode_e      op;
  alu_fn_e      fn;
  wb_sel_e      wsel;
  logic         rf_we, is_st, is_br, is_jmp, use_base, take;
  logic         dm_we;
  logic [DAW-1:0] dm_wa;
  logic [W-1:0]   dm_wd;

  assign instr = imem[pc_q[IAW-1:0]];
  assign op    = opcode_e'(instr[15:12]);
  assign pc1   = pc_q + 16'd1;

  always_comb begin
    rf_we = 1'b0; is_st = 1'b0; is_br = 1'b0; is_jmp = 1'b0;
    use_base = 1'b0; fn = ALU_ADD; wsel = WB_ALU;
    case (op)
      OP_ADD:  rf_we = 1'b1;
      OP_AND:  begin rf_we = 1'b1; fn = ALU_AND; end
      OP_INV:  begin rf_we = 1'b1; fn = ALU_INV; end
      OP_LDPC: begin rf_we = 1'b1; wsel = WB_MEM; end
      OP_LDBO: begin rf_we = 1'b1; wsel = WB_MEM; use_base = 1'b1; end
      OP_ADDR: begin rf_we = 1'b1; wsel = WB_AGU; end
      OP_STPC: is_st = 1'b1;
      OP_STBO: begin is_st = 1'b1; use_base = 1'b1; end
      OP_BR:   is_br = 1'b1;
      OP_JREG: is_jmp = 1'b1;
      default: ;
    endcase
  end

  assign rb_sel = is_st ? instr[11:9] : instr[2:0];

  oc_regfile #(.NREG(8)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we & ~rst), .wa(instr[11:9]), .wd(wd),
    .ra(instr[8:6]), .rb(rb_sel), .rda(rda), .rdb(rdb), .regs_flat(dbg_regs)
  );

  oc_agu u_agu (
    .pc1(pc1), .base(rda), .off(instr[8:0]), .use_base(use_base), .addr(addr)
  );

  oc_alu u_alu (
    .fn(fn), .a(rda), .b(rdb), .imm_en(instr[5]), .imm(instr[4:0]), .y(alu_y)
  );

  assign dm_rd = dmem[addr[DAW-1:0]];

  always_comb begin
    case (wsel)
      WB_MEM:  wd = dm_rd;
      WB_AGU:  wd = addr;
      default: wd = alu_y;
    endcase
  end

  assign take  = |(instr[11:9] & cc_q);
  assign pc_nx = is_jmp ? rda : ((is_br && take) ? addr : pc1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
      cc_q <= 3'b010;
    end else begin
      pc_q <= pc_nx;
      if (rf_we) cc_q <= flags_of(wd);
    end
  end

  // single write port per array: loader or store
  assign dm_we = (ld_we & ld_sel) | (is_st & ~rst);
  assign dm_wa = (ld_we & ld_sel) ? ld_addr[DAW-1:0] : addr[DAW-1:0];
  assign dm_wd = (ld_we & ld_sel) ? ld_data : rdb;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_wa] <= dm_wd;
  end

  always_ff @(posedge clk) begin
    if (ld_we && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  assign dbg_pc = pc_q;
  assign dbg_cc = cc_q;

  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(cc_q) == 1); // R9
  AST_CC_KEEP: assert property (@(posedge clk) disable iff (rst)
    !rf_we |=> $stable(cc_q)); // R6
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!is_br && !is_jmp) |=> pc_q == $past(pc_q) + 16'd1); // R10
  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    is_jmp |=> pc_q == $past(rda)); // R8
  AST_BR_NEVER: assert property (@(posedge clk) disable iff (rst)
    (is_br && instr[11:9] == 3'b000) |=> pc_q == $past(pc_q) + 16'd1); // R7
endmodule

// File: tb/oc_core_test.sv
module oc_core_test;
  localparam int ID = 256;
  localparam int DD = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_sel = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] dbg_pc;
  logic [127:0] dbg_regs;
  logic [2:0]  dbg_cc;

  always #4 clk = ~clk;

  oc_core #(.RESET_PC(16'h3000), .IMEM_DEPTH(ID), .DMEM_DEPTH(DD)) uut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs), .dbg_cc(dbg_cc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_imem [ID];
  logic [15:0] m_dmem [DD];
  logic [15:0] m_reg  [8];
  logic [15:0] m_pc;
  logic [2:0]  m_cc;

  function automatic logic [15:0] e_rr(logic [3:0] op, logic [2:0] d, logic [2:0] s, logic [2:0] t);
    return {op, d, s, 3'b000, t};
  endfunction
  function automatic logic [15:0] e_ri(logic [3:0] op, logic [2:0] d, logic [2:0] s, logic [4:0] k);
    return {op, d, s, 1'b1, k};
  endfunction
  function automatic logic [15:0] e_pc(logic [3:0] op, logic [2:0] d, logic [8:0] o);
    return {op, d, o};
  endfunction
  function automatic logic [15:0] e_bo(logic [3:0] op, logic [2:0] d, logic [2:0] b, logic [5:0] o);
    return {op, d, b, o};
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at pc=%h", tag, what, act, exp, m_pc);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "pc", dbg_pc, m_pc);
    check("R9", "flags", {13'b0, dbg_cc}, {13'b0, m_cc});
    for (int r = 0; r < 8; r++)
      check(tag, $sformatf("reg%0d", r), dbg_regs[r*16 +: 16], m_reg[r]);
  endtask

  task automatic model_step(output string tag);
    logic [15:0] ins, pc1, s5, s6, s9, v, a, nxt;
    logic [2:0]  dr, s1;
    logic        wr;
    ins = m_imem[m_pc[7:0]];
    pc1 = m_pc + 16'd1;
    dr  = ins[11:9];
    s1  = ins[8:6];
    s5  = {{11{ins[4]}}, ins[4:0]};
    s6  = {{10{ins[5]}}, ins[5:0]};
    s9  = {{7{ins[8]}}, ins[8:0]};
    wr  = 1'b0; v = '0; nxt = pc1;
    case (ins[15:12])
      4'h1: begin v = m_reg[s1] + (ins[5] ? s5 : m_reg[ins[2:0]]); wr = 1'b1; tag = "R2"; end
      4'h5: begin v = m_reg[s1] & (ins[5] ? s5 : m_reg[ins[2:0]]); wr = 1'b1; tag = "R2"; end
      4'h9: begin v = ~m_reg[s1]; wr = 1'b1; tag = "R3"; end
      4'h2: begin a = pc1 + s9; v = m_dmem[a[7:0]]; wr = 1'b1; tag = "R4"; end
      4'he: begin v = pc1 + s9; wr = 1'b1; tag = "R4"; end
      4'h6: begin a = m_reg[s1] + s6; v = m_dmem[a[7:0]]; wr = 1'b1; tag = "R5"; end
      4'h3: begin a = pc1 + s9; m_dmem[a[7:0]] = m_reg[dr]; tag = "R6"; end
      4'h7: begin a = m_reg[s1] + s6; m_dmem[a[7:0]] = m_reg[dr]; tag = "R6"; end
      4'h0: begin if (|(ins[11:9] & m_cc)) nxt = pc1 + s9; tag = "R7"; end
      4'hc: begin nxt = m_reg[s1]; tag = "R8"; end
      default: tag = "R10";
    endcase
    if (wr) begin
      m_reg[dr] = v;
      m_cc = v[15] ? 3'b100 : ((v == 16'h0) ? 3'b010 : 3'b001);
    end
    m_pc = nxt;
  endtask

  task automatic load_and_reset();
    rst = 1'b1;
    for (int i = 0; i < ID; i++) begin
      @(negedge clk); ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 8'(i); ld_data = m_imem[i];
    end
    for (int i = 0; i < DD; i++) begin
      @(negedge clk); ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 8'(i); ld_data = m_dmem[i];
    end
    @(negedge clk); ld_we = 1'b0;
    @(negedge clk);
    m_pc = 16'h3000; m_cc = 3'b010;
    for (int r = 0; r < 8; r++) m_reg[r] = '0;
    compare_all("R1");
    rst = 1'b0;
  endtask

  task automatic run(int n);
    string tag;
    for (int c = 0; c < n; c++) begin
      model_step(tag);
      @(negedge clk);
      compare_all(tag);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    // directed program at 0x3000 (index 0)
    for (int i = 0; i < ID; i++) m_imem[i] = 16'h0000;
    for (int i = 0; i < DD; i++) m_dmem[i] = 16'(i * 16'h0123 + 16'h8001);
    m_imem[0]  = e_ri(4'h5, 3'd1, 3'd1, 5'h00);   // clear R1
    m_imem[1]  = e_ri(4'h1, 3'd1, 3'd1, 5'h05);   // R1 = 5
    m_imem[2]  = e_ri(4'h1, 3'd2, 3'd1, 5'h10);   // R2 = 5-16
    m_imem[3]  = e_rr(4'h1, 3'd3, 3'd1, 3'd2);    // R3 = R1+R2
    m_imem[4]  = e_rr(4'h5, 3'd4, 3'd3, 3'd1);    // R4 = R3&R1 -> 0
    m_imem[5]  = {4'h9, 3'd5, 3'd1, 6'h3f};       // R5 = ~R1
    m_imem[6]  = e_pc(4'he, 3'd6, 9'd10);         // R6 = address
    m_imem[7]  = e_pc(4'h3, 3'd1, 9'd20);         // store R1
    m_imem[8]  = e_pc(4'h2, 3'd7, 9'd19);         // load same word
    m_imem[9]  = e_bo(4'h7, 3'd2, 3'd6, 6'h3f);   // store R2 at R6-1
    m_imem[10] = e_bo(4'h6, 3'd6, 3'd6, 6'h3f);   // R6 = mem[R6-1], dest = base
    m_imem[11] = {4'h0, 3'b010, 9'd2};            // z clear: not taken
    m_imem[12] = {4'h0, 3'b100, 9'd1};            // n set: taken
    m_imem[13] = e_ri(4'h1, 3'd0, 3'd0, 5'h01);   // skipped
    m_imem[14] = 16'h8000;                        // unsupported
    m_imem[15] = 16'hF025;                        // unsupported
    m_imem[16] = {4'h0, 3'b000, 9'd5};            // never branches
    m_imem[17] = e_pc(4'he, 3'd0, 9'd3);          // R0 = 0x3015
    m_imem[18] = {4'hc, 3'b000, 3'd0, 6'h00};     // jump R0
    m_imem[19] = e_ri(4'h1, 3'd1, 3'd1, 5'h01);
    m_imem[20] = e_ri(4'h1, 3'd1, 3'd1, 5'h01);
    m_imem[21] = e_ri(4'h1, 3'd1, 3'd1, 5'h1b);   // R1 = 0
    m_imem[22] = e_pc(4'h2, 3'd3, 9'd40);         // load preset word
    m_imem[23] = {4'h0, 3'b111, 9'h1ff};          // loop forever
    load_and_reset();
    run(40);

    // random instruction stream
    for (int i = 0; i < ID; i++) m_imem[i] = 16'($urandom);
    for (int i = 0; i < DD; i++) m_dmem[i] = 16'($urandom);
    load_and_reset();
    run(400);

    finish_up();
  end
endmodule